// File: doc/BRIEF.md
# Presence-Detect Configuration EEPROM Target

This block is a two-wire serial target (I2C style) that models a 256-byte non-volatile configuration memory of the kind a memory module carries to describe itself. It runs on a fast system clock and oversamples the bus lines. Each line passes through a synchroniser and a glitch filter before start, stop and clock-edge events are decoded. The device answers to a 7-bit address. The upper four bits are the fixed type code 1010 and the lower three come from static strap pins. It supports a single-byte write, a random read (a word-address write followed by a repeated START and a read) and sequential or current-address reads.

The lower half of the array is permanently locked. Writes to the upper half are allowed only while the write-protect input is low. A write is committed on the STOP that ends it. An internal programming window then starts, and for its whole length the target ignores the bus and does not acknowledge its address. The power-up contents come from a parameter image. The default image is computed so that byte 63 holds the 8-bit checksum of bytes 0 to 62. SDA is open-drain: the block only outputs a pull-low enable.

Top module: `spd_eeprom_target`

## Requirements
- R1: The target acknowledges a device-address byte whose bits [7:4] are 1010 and whose bits [3:1] equal strap_addr_i (bit 1 of the byte is strap bit 0). It does not acknowledge any other address, and bit 0 of the byte selects write (0) or read (1).
- R2: A write of a word address, then a repeated START and a read address, returns the byte stored at that word address, MSB first.
- R3: Reads auto-increment the address pointer, wrapping from 255 to 0. A read that starts without a word address continues from the pointer left by the last access. The master ends a read with NACK then STOP.
- R4: After reset, byte i holds (29*i+7) mod 256 for i from 0 to 62. Byte 63 holds the low 8 bits of the sum of bytes 0 to 62. Byte i holds i XOR 0xA5 for i from 64 to 255.
- R5: A write to an address below 128 is acknowledged on every byte, but it leaves the array unchanged and starts no programming window.
- R6: With wp_i high at the STOP, a write to an address of 128 or above is acknowledged, changes nothing and starts no window. With wp_i low, the byte is stored.
- R7: A stored write takes effect at STOP and starts a window of PROG_CYC clock cycles. During that window the device address is not acknowledged. Afterwards it is acknowledged again.
- R8: The array accepts only one data byte per write transfer. The first data byte is acknowledged, and a second data byte in the same transfer is not acknowledged and is discarded.
- R9: A pulse shorter than GLITCH_CYC clock cycles on SCL or SDA is ignored.
- R10: The pull-low enable changes only while the filtered SCL is low.
- R11: Out of reset the block does not pull SDA low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus (wired-AND) |
| strap_addr_i | input | 3 | Static low device-address bits |
| wp_i | input | 1 | Write protect for the upper half of the array |
| sda_low_o | output | 1 | Open-drain pull-low enable for SDA |

## Verification
The bench uses a bit-level master to attack the places where a target of this kind usually breaks. It reads across the 255-to-0 wrap, and a pointer that saturates or fails to wrap returns the wrong bytes. It writes to locked and protected bytes, where a design that commits the data or opens the programming window would either read back changed data or refuse the next poll. It polls immediately after a real write, and a target without the busy window would acknowledge that poll. It sends a second data byte in one transfer, which a design without the single-byte limit would acknowledge. It also injects a short SCL dropout inside an address bit; a missing filter would shift the address and refuse the transfer.

// File: rtl/spd_pkg.sv
package spd_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam int         MEM_BYTES = 256;

  typedef logic [7:0] img_t [MEM_BYTES];

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR, ST_ADDR_ACK, ST_WORD, ST_WORD_ACK,
    ST_WDAT, ST_WDAT_ACK, ST_RD, ST_RD_ACK
  } bus_state_t;

  // Power-up image: arithmetic body, checksum at byte 63, patterned top.
  function automatic img_t default_image();
    img_t       im;
    logic [7:0] acc;
    acc = 8'h00;
    for (int i = 0; i < MEM_BYTES; i++) begin
      if (i < 63) begin
        im[i] = 8'(i * 29 + 7);
        acc   = acc + im[i];
      end else if (i == 63) begin
        im[i] = acc;
      end else begin
        im[i] = 8'(i) ^ 8'hA5;
      end
    end
    return im;
  endfunction

  // Upper half only, and only while protection is off.
  function automatic logic cell_writable(logic [7:0] addr, logic prot);
    return addr[7] & ~prot;
  endfunction

  function automatic logic addr_hit(logic [6:0] dev, logic [2:0] strap);
    return dev == {DEV_TYPE, strap};
  endfunction

endpackage

// File: rtl/spd_glitch_filter.sv
module spd_glitch_filter #(
  parameter int HOLD_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_i,
  output logic clean_o
);
  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1      <= 1'b1;
      s2      <= 1'b1;
      cnt     <= '0;
      clean_o <= 1'b1;
    end else begin
      s1 <= raw_i;
      s2 <= s1;
      if (s2 == clean_o) begin
        cnt <= '0;
      end else if (cnt == CW'(HOLD_CYC - 1)) begin
        clean_o <= s2;
        cnt     <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spd_prog_timer.sv
module spd_prog_timer #(
  parameter int PROG_CYC = 3_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(PROG_CYC + 1);

  logic [CW-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (start_i)        remain <= CW'(PROG_CYC);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign busy_o = (remain != '0);
endmodule

// File: rtl/spd_store.sv
module spd_store #(
  parameter spd_pkg::img_t INIT_IMG = spd_pkg::default_image()
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en_i,
  input  logic [7:0] wr_addr_i,
  input  logic [7:0] wr_data_i,
  input  logic [7:0] rd_addr_i,
  output logic [7:0] rd_data_o
);
  logic [7:0] cells [spd_pkg::MEM_BYTES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < spd_pkg::MEM_BYTES; i++) cells[i] <= INIT_IMG[i];
    end else if (wr_en_i) begin
      cells[wr_addr_i] <= wr_data_i;
    end
  end

  assign rd_data_o = cells[rd_addr_i];
endmodule

// File: rtl/spd_eeprom_target.sv
module spd_eeprom_target
  import spd_pkg::*;
#(
  parameter int   GLITCH_CYC = 4,
  parameter int   PROG_CYC   = 3_750_000,
  parameter img_t INIT_IMG   = default_image()
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [2:0] strap_addr_i,
  input  logic       wp_i,
  output logic       sda_low_o
);
  // Filtered lines: index 0 = SCL, index 1 = SDA
  logic [1:0] line_raw, line_f;
  assign line_raw = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    spd_glitch_filter #(.HOLD_CYC(GLITCH_CYC)) u_filt (
      .clk(clk), .rst_n(rst_n), .raw_i(line_raw[g]), .clean_o(line_f[g])
    );
  end

  logic scl_f, sda_f, scl_q, sda_q;
  assign scl_f = line_f[0];
  assign sda_f = line_f[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  // Named bus events
  logic scl_rise, scl_fall, start_ev, stop_ev;
  assign scl_rise = scl_f & ~scl_q;
  assign scl_fall = ~scl_f & scl_q;
  assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;

  bus_state_t state;
  logic [3:0] bitcnt;
  logic [7:0] shreg, ptr, pend_addr, pend_data, rd_data;
  logic       pend, rw, mack, busy, wr_en;

  // Commit on STOP only when the pending cell accepts writes
  assign wr_en = stop_ev & pend & ~busy & cell_writable(pend_addr, wp_i);

  spd_prog_timer #(.PROG_CYC(PROG_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .start_i(wr_en), .busy_o(busy)
  );

  spd_store #(.INIT_IMG(INIT_IMG)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(pend_addr),
    .wr_data_i(pend_data), .rd_addr_i(ptr), .rd_data_o(rd_data)
  );

  logic rx_state;
  assign rx_state = (state == ST_ADDR) || (state == ST_WORD) || (state == ST_WDAT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE; bitcnt <= '0; shreg <= '0; ptr <= '0;
      pend <= 1'b0; pend_addr <= '0; pend_data <= '0;
      rw <= 1'b0; mack <= 1'b0; sda_low_o <= 1'b0;
    end else if (busy) begin
      state <= ST_IDLE; sda_low_o <= 1'b0; pend <= 1'b0;
    end else if (start_ev) begin
      state <= ST_ADDR; bitcnt <= '0; sda_low_o <= 1'b0; pend <= 1'b0;
    end else if (stop_ev) begin
      state <= ST_IDLE; sda_low_o <= 1'b0; pend <= 1'b0;
    end else begin
      if (scl_rise && rx_state) begin
        shreg  <= {shreg[6:0], sda_f};
        bitcnt <= bitcnt + 1'b1;
      end
      if (scl_rise && state == ST_RD)     bitcnt <= bitcnt + 1'b1;
      if (scl_rise && state == ST_RD_ACK) mack <= ~sda_f;
      if (scl_fall) begin
        unique case (state)
          ST_ADDR: if (bitcnt == 4'd8) begin
            if (addr_hit(shreg[7:1], strap_addr_i)) begin
              sda_low_o <= 1'b1; rw <= shreg[0]; state <= ST_ADDR_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_WORD: if (bitcnt == 4'd8) begin
            ptr <= shreg; sda_low_o <= 1'b1; state <= ST_WORD_ACK;
          end
          ST_WDAT: if (bitcnt == 4'd8) begin
            if (!pend) begin
              pend <= 1'b1; pend_addr <= ptr; pend_data <= shreg;
              ptr <= ptr + 1'b1; sda_low_o <= 1'b1; state <= ST_WDAT_ACK;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_ADDR_ACK, ST_RD_ACK: begin
            bitcnt <= '0;
            if ((state == ST_ADDR_ACK && rw) || (state == ST_RD_ACK && mack)) begin
              shreg <= {rd_data[6:0], 1'b0}; sda_low_o <= ~rd_data[7];
              ptr <= ptr + 1'b1; state <= ST_RD;
            end else begin
              sda_low_o <= 1'b0;
              state <= (state == ST_ADDR_ACK) ? ST_WORD : ST_IDLE;
            end
          end
          ST_WORD_ACK, ST_WDAT_ACK: begin
            sda_low_o <= 1'b0; bitcnt <= '0; state <= ST_WDAT;
          end
          ST_RD: begin
            if (bitcnt == 4'd8) begin
              sda_low_o <= 1'b0; state <= ST_RD_ACK;
            end else begin
              sda_low_o <= ~shreg[7]; shreg <= {shreg[6:0], 1'b0};
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/spd_eeprom_chk.sv
module spd_eeprom_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_f,
  input logic       sda_low_o,
  input logic       busy,
  input logic       wr_en,
  input logic       stop_ev,
  input logic [7:0] pend_addr,
  input logic       wp_i
);
  assert_lower_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> pend_addr[7]);

  assert_wp_blocks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !wp_i);

  assert_commit_at_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> stop_ev);

  assert_window_opens_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> busy);

  assert_window_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en));

  assert_silent_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_low_o);

  assert_drive_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_low_o) |-> !$past(scl_f));
endmodule

bind spd_eeprom_target spd_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_low_o(sda_low_o),
  .busy(busy), .wr_en(wr_en), .stop_ev(stop_ev), .pend_addr(pend_addr),
  .wp_i(wp_i)
);

// File: tb/sim_spd_eeprom_target.sv
module sim_spd_eeprom_target;
  localparam int Q     = 12;
  localparam int PROG  = 1500;
  localparam int GLT   = 4;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_low = 1'b0, wp = 1'b0, glitch_next = 1'b0;
  logic sda_low;
  wire  sda_line = ~(m_low | sda_low);

  always #2 clk = ~clk;

  spd_eeprom_target #(.GLITCH_CYC(GLT), .PROG_CYC(PROG)) u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
    .strap_addr_i(STRAP), .wp_i(wp), .sda_low_o(sda_low)
  );

  int n_cmp = 0, n_bad = 0, edge_viol = 0;
  bit done = 0;
  logic [7:0] model [256];
  logic [7:0] rbuf [64];
  logic prev_low = 1'b0;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // R10 monitor: pull-low edges seen on the pin while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_low !== prev_low && m_scl) edge_viol++;
    prev_low = sda_low;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_run();
  end

  task automatic w(int n); repeat (n) @(negedge clk); endtask

  task automatic bus_start();
    m_low = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_low = 1'b1; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic bus_stop();
    m_low = 1'b1; w(Q); m_scl = 1'b1; w(Q); m_low = 1'b0; w(3 * Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      m_low = ~b[i]; w(Q); m_scl = 1'b1;
      if (glitch_next && i == 4) begin
        w(Q); m_scl = 1'b0; w(GLT - 2); m_scl = 1'b1; w(Q - GLT + 2);
        glitch_next = 1'b0;
      end else begin
        w(2 * Q);
      end
      m_scl = 1'b0; w(Q);
    end
    m_low = 1'b0; w(Q); m_scl = 1'b1; w(Q); ack = ~sda_line; w(Q); m_scl = 1'b0; w(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      w(Q); m_scl = 1'b1; w(Q); b[i] = sda_line; w(Q); m_scl = 1'b0;
    end
    w(Q); m_low = give_ack; m_scl = 1'b1; w(2 * Q); m_scl = 1'b0; w(Q); m_low = 1'b0;
  endtask

  function automatic logic [7:0] dev(bit rd); return {4'b1010, STRAP, rd}; endfunction

  task automatic poll(output bit ack);
    bus_start(); send_byte(dev(0), ack); bus_stop();
  endtask

  task automatic write_tx(input logic [7:0] a, input logic [7:0] d, output bit acks);
    bit a0, a1, a2;
    bus_start(); send_byte(dev(0), a0); send_byte(a, a1); send_byte(d, a2); bus_stop();
    acks = a0 & a1 & a2;
  endtask

  task automatic read_tx(input logic [7:0] a, input int n, output bit acks);
    bit a0, a1, a2;
    bus_start(); send_byte(dev(0), a0); send_byte(a, a1);
    bus_start(); send_byte(dev(1), a2);
    for (int k = 0; k < n; k++) recv_byte(rbuf[k], k != n - 1);
    bus_stop();
    acks = a0 & a1 & a2;
  endtask

  initial begin
    bit ok, ack;
    logic [7:0] sum, a, d, x;
    void'($urandom(32'd1234));
    // independent model of the power-up image (R4)
    for (int i = 0; i < 256; i++)
      model[i] = (i < 63) ? 8'((29 * i + 7) % 256) : (i > 63) ? (8'(i) ^ 8'hA5) : 8'h00;
    sum = 0;
    for (int i = 0; i < 63; i++) sum = sum + model[i];
    model[63] = sum;

    w(5);
    chk(sda_low == 1'b0, "R11 reset no pull", sda_low, 0);
    rst_n = 1'b1; w(10);
    chk(sda_low == 1'b0, "R11 idle after reset", sda_low, 0);

    // R4 / R2: whole lower quarter in one sequential read
    read_tx(8'd0, 64, ok);
    chk(ok, "R2 random read acks", ok, 1);
    sum = 0;
    for (int i = 0; i < 64; i++) begin
      chk(rbuf[i] == model[i], $sformatf("R4 byte %0d", i), rbuf[i], model[i]);
      if (i < 63) sum = sum + rbuf[i];
    end
    chk(rbuf[63] == sum, "R4 checksum byte 63", rbuf[63], sum);

    // R1 addressing
    bus_start(); send_byte({4'b1010, 3'b011, 1'b0}, ack); bus_stop();
    chk(!ack, "R1 foreign strap NACK", ack, 0);
    bus_start(); send_byte({4'b1011, STRAP, 1'b0}, ack); bus_stop();
    chk(!ack, "R1 foreign type NACK", ack, 0);
    poll(ack);
    chk(ack, "R1 own address ACK", ack, 1);

    // R3 wrap and current-address continuation
    read_tx(8'd254, 4, ok);
    chk(ok, "R3 read acks", ok, 1);
    chk(rbuf[0] == model[254], "R3 byte 254", rbuf[0], model[254]);
    chk(rbuf[1] == model[255], "R3 byte 255", rbuf[1], model[255]);
    chk(rbuf[2] == model[0], "R3 wrap to 0", rbuf[2], model[0]);
    chk(rbuf[3] == model[1], "R3 byte 1", rbuf[3], model[1]);
    bus_start(); send_byte(dev(1), ack); recv_byte(x, 0); bus_stop();
    chk(ack && x == model[2], "R3 current-address read", x, model[2]);

    // R5 locked lower half
    write_tx(8'd10, 8'h3C, ok);
    chk(ok, "R5 locked write acked", ok, 1);
    poll(ack);
    chk(ack, "R5 no window after locked write", ack, 1);
    read_tx(8'd10, 1, ok);
    chk(rbuf[0] == model[10], "R5 locked byte unchanged", rbuf[0], model[10]);

    // R6 protect pin, R7 window
    wp = 1'b1;
    write_tx(8'd200, 8'h11, ok);
    chk(ok, "R6 protected write acked", ok, 1);
    poll(ack);
    chk(ack, "R6 no window when protected", ack, 1);
    read_tx(8'd200, 1, ok);
    chk(rbuf[0] == model[200], "R6 protected byte unchanged", rbuf[0], model[200]);
    wp = 1'b0;
    write_tx(8'd200, 8'h11, ok);
    model[200] = 8'h11;
    poll(ack);
    chk(!ack, "R7 busy window NACK", ack, 0);
    w(PROG + 100);
    poll(ack);
    chk(ack, "R7 ACK after window", ack, 1);
    read_tx(8'd200, 1, ok);
    chk(rbuf[0] == 8'h11, "R6 unprotected byte stored", rbuf[0], 8'h11);

    // R8 second data byte refused
    bus_start(); send_byte(dev(0), ack); send_byte(8'd130, ack); send_byte(8'h77, ack);
    chk(ack, "R8 first data byte ACK", ack, 1);
    send_byte(8'h88, ack); bus_stop();
    chk(!ack, "R8 second data byte NACK", ack, 0);
    model[130] = 8'h77;
    w(PROG + 100);
    read_tx(8'd130, 2, ok);
    chk(rbuf[0] == 8'h77, "R8 first byte kept", rbuf[0], 8'h77);
    chk(rbuf[1] == model[131], "R8 next cell untouched", rbuf[1], model[131]);

    // R9 short SCL dropout inside an address bit
    bus_start(); glitch_next = 1'b1; send_byte(dev(0), ack); bus_stop();
    chk(ack, "R9 glitch ignored", ack, 1);

    // Random writes and reads in the upper half
    for (int it = 0; it < 6; it++) begin
      a = 8'd128 + 8'($urandom_range(0, 127));
      d = 8'($urandom);
      wp = 1'($urandom_range(0, 1));
      write_tx(a, d, ok);
      chk(ok, "R6 random write acked", ok, 1);
      poll(ack);
      chk(ack == wp, "R7 window follows protect", ack, wp);
      if (!wp) begin model[a] = d; w(PROG + 100); end
      wp = 1'b0;
      read_tx(a, 1, ok);
      chk(rbuf[0] == model[a], "R2 random readback", rbuf[0], model[a]);
    end
    for (int it = 0; it < 4; it++) begin
      a = 8'($urandom);
      read_tx(a, 3, ok);
      for (int k = 0; k < 3; k++)
        chk(rbuf[k] == model[8'(a + k)], "R3 random sequential", rbuf[k], model[8'(a + k)]);
    end

    chk(edge_viol == 0, "R10 SDA edges with SCL low", edge_viol, 0);
    finish_run();
  end
endmodule